// File: doc/BRIEF.md
# Split nibble register file

This block holds eight 4-bit entries in a single storage array and offers two ways into it. The narrow view has eight read ports and eight write ports. Each port picks its entries with an 8-bit one-hot (unary) select vector, with one bit per entry, so there is no address decoding. The wide view has one read port and one write port. These move all eight entries together as one 32-bit word, with entry i in bits [4i+3:4i].

All reads are combinational and forward same-cycle writes. A read of an entry that is being written in the current cycle returns the incoming value, not the stored one. Writes are taken on the rising clock edge. When several writers target one entry, the narrow ports take precedence over the wide port, and among the narrow ports the highest-numbered one wins. A synchronous active-high reset clears every entry.

Top module: `nibble_split_rf`

## Requirements
- R1: After a synchronous reset with no writes pending, the wide read word is 0 and every narrow read returns 0.
- R2: A value written through a narrow port is returned by a later read of that entry with no write active, starting from the cycle after the write edge.
- R3: A narrow read port with an all-zero select vector outputs 0. With exactly one select bit i set, it outputs entry i.
- R4: A narrow read port with several select bits set outputs the bitwise OR of the selected entries' (forwarded) values.
- R5: A narrow read of an entry that is written in the same cycle returns the data being written (write-through), before the clock edge.
- R6: A wide write (wwr_en=1) stores wwr_data bits [4i+3:4i] into entry i for every entry that no narrow port writes in that cycle.
- R7: The wide read word is always valid. Nibble i equals entry i, or the data of any same-cycle write to entry i.
- R8: When a narrow write and the wide write target the same entry in one cycle, the narrow data is stored and forwarded.
- R9: When several narrow write ports target the same entry, the highest-numbered port's data is stored and forwarded.
- R10: A narrow write port with several select bits set writes its data into every selected entry.
- R11: An entry that no port writes keeps its value.
- R12: Reset takes priority over any writes in the same cycle. All entries read 0 afterwards.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| nrd_sel | input | 8x8 | Per narrow read port, one-hot entry select ([port][entry]) |
| nrd_data | output | 8x4 | Per narrow read port, OR of selected entries |
| nwr_sel | input | 8x8 | Per narrow write port, entry select ([port][entry]) |
| nwr_data | input | 8x4 | Per narrow write port, data |
| wwr_en | input | 1 | Wide write enable |
| wwr_data | input | 32 | Wide write word, entry i at bits [4i+3:4i] |
| wrd_data | output | 32 | Wide read word, entry i at bits [4i+3:4i] |

## Verification
Every read result is combinational and is due in the same cycle as the select and write inputs that produce it. Stored values change only at the next rising edge. The bench drives its inputs on the falling edge and compares all nine read outputs one time unit later against values forwarded from its own model. It then advances the model at the rising edge. This way each write is checked twice: once as write-through before the edge, and once as stored data in the following cycle. The sweeps cover every write port against every entry, all 256 select patterns on one read port, and the priority cases.

// File: rtl/nsrf_pkg.sv
package nsrf_pkg;
    localparam int ENT_W  = 4;
    localparam int N_ENT  = 8;
    localparam int N_NRD  = 8;
    localparam int N_NWR  = 8;
    localparam int WORD_W = ENT_W * N_ENT;

    typedef logic [ENT_W-1:0] nib_t;
    typedef logic [N_ENT-1:0] ent_sel_t;
    typedef logic [N_NWR-1:0] wr_sel_t;

    // winning write for one entry in the current cycle
    typedef struct packed {
        logic hit;
        nib_t val;
    } wr_pick_t;

    function automatic nib_t word_nib(input logic [WORD_W-1:0] w, input int i);
        return w[i*ENT_W +: ENT_W];
    endfunction
endpackage

// File: rtl/nsrf_wpick.sv
module nsrf_wpick
    import nsrf_pkg::*;
(
    input  wr_sel_t          nsel,
    input  nib_t [N_NWR-1:0] nwr_data,
    input  logic             wide_en,
    input  nib_t             wide_val,
    output wr_pick_t         pick
);
    // wide port lowest priority; later (higher) narrow ports override
    always_comb begin
        pick.hit = wide_en;
        pick.val = wide_val;
        for (int p = 0; p < N_NWR; p++) begin
            if (nsel[p]) begin
                pick.hit = 1'b1;
                pick.val = nwr_data[p];
            end
        end
    end
endmodule

// File: rtl/nsrf_entry.sv
module nsrf_entry
    import nsrf_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  wr_sel_t          nsel,
    input  nib_t [N_NWR-1:0] nwr_data,
    input  logic             wide_en,
    input  nib_t             wide_val,
    output nib_t             fwd
);
    nib_t     q;
    wr_pick_t pick;

    nsrf_wpick u_pick (
        .nsel     (nsel),
        .nwr_data (nwr_data),
        .wide_en  (wide_en),
        .wide_val (wide_val),
        .pick     (pick)
    );

    always_ff @(posedge clk) begin
        if (rst)           q <= '0;
        else if (pick.hit) q <= pick.val;
    end

    assign fwd = pick.hit ? pick.val : q;

    assert_visible_R2: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> q == $past(fwd));
    assert_hold_R11: assert property (@(posedge clk) disable iff (rst)
        (nsel == '0 && !wide_en) |=> q == $past(q));
    assert_wide_only_R6: assert property (@(posedge clk) disable iff (rst)
        (wide_en && nsel == '0) |=> q == $past(wide_val));
    assert_narrow_beats_wide_R8: assert property (@(posedge clk) disable iff (rst)
        (wide_en && nsel == wr_sel_t'(1)) |=> q == $past(nwr_data[0]));
    assert_top_port_wins_R9: assert property (@(posedge clk) disable iff (rst)
        nsel[N_NWR-1] |=> q == $past(nwr_data[N_NWR-1]));
endmodule

// File: rtl/nsrf_rdor.sv
module nsrf_rdor
    import nsrf_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  ent_sel_t         sel,
    input  nib_t [N_ENT-1:0] ents,
    output nib_t             q
);
    always_comb begin
        q = '0;
        for (int e = 0; e < N_ENT; e++) begin
            if (sel[e]) q = q | ents[e];
        end
    end

    assert_deselect_zero_R3: assert property (@(posedge clk) disable iff (rst)
        (sel == '0) |-> q == '0);
endmodule

// File: rtl/nibble_split_rf.sv
module nibble_split_rf
    import nsrf_pkg::*;
(
    input  logic                            clk,
    input  logic                            rst,
    input  logic [N_NRD-1:0][N_ENT-1:0]     nrd_sel,
    output logic [N_NRD-1:0][ENT_W-1:0]     nrd_data,
    input  logic [N_NWR-1:0][N_ENT-1:0]     nwr_sel,
    input  logic [N_NWR-1:0][ENT_W-1:0]     nwr_data,
    input  logic                            wwr_en,
    input  logic [WORD_W-1:0]               wwr_data,
    output logic [WORD_W-1:0]               wrd_data
);
    nib_t [N_ENT-1:0] ent_fwd;
    nib_t [N_NWR-1:0] nwr_nib;

    assign nwr_nib = nwr_data;

    for (genvar e = 0; e < N_ENT; e++) begin : g_ent
        wr_sel_t col;
        for (genvar p = 0; p < N_NWR; p++) begin : g_col
            assign col[p] = nwr_sel[p][e];
        end

        nsrf_entry u_entry (
            .clk      (clk),
            .rst      (rst),
            .nsel     (col),
            .nwr_data (nwr_nib),
            .wide_en  (wwr_en),
            .wide_val (word_nib(wwr_data, e)),
            .fwd      (ent_fwd[e])
        );

        assign wrd_data[e*ENT_W +: ENT_W] = ent_fwd[e];
    end

    for (genvar r = 0; r < N_NRD; r++) begin : g_rd
        nsrf_rdor u_rd (
            .clk  (clk),
            .rst  (rst),
            .sel  (nrd_sel[r]),
            .ents (ent_fwd),
            .q    (nrd_data[r])
        );
    end

    assert_wide_wt_R7: assert property (@(posedge clk) disable iff (rst)
        (wwr_en && nwr_sel == '0) |-> wrd_data == wwr_data);
endmodule

// File: tb/nibble_split_rf_tb.sv
module nibble_split_rf_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NE = 8;
    localparam int NR = 8;
    localparam int NW = 8;

    logic                   clk = 1'b0;
    logic                   rst;
    logic [NR-1:0][NE-1:0]  nrd_sel;
    logic [NR-1:0][3:0]     nrd_data;
    logic [NW-1:0][NE-1:0]  nwr_sel;
    logic [NW-1:0][3:0]     nwr_data;
    logic                   wwr_en;
    logic [31:0]            wwr_data;
    logic [31:0]            wrd_data;

    int checks = 0;
    int errors = 0;
    logic [3:0] model [NE];
    logic [3:0] ef    [NE];

    always #(CLK_PERIOD/2) clk = ~clk;

    nibble_split_rf u_dut (
        .clk(clk), .rst(rst), .nrd_sel(nrd_sel), .nrd_data(nrd_data),
        .nwr_sel(nwr_sel), .nwr_data(nwr_data), .wwr_en(wwr_en),
        .wwr_data(wwr_data), .wrd_data(wrd_data)
    );

    // expected forwarded value per entry from the stated priority rules
    task automatic compute_fwd();
        for (int e = 0; e < NE; e++) begin
            ef[e] = model[e];
            if (wwr_en) ef[e] = wwr_data[e*4 +: 4];
            for (int p = 0; p < NW; p++)
                if (nwr_sel[p][e]) ef[e] = nwr_data[p];
        end
    endtask

    task automatic check_all(input string tag);
        logic [31:0] w;
        logic [3:0]  o;
        compute_fwd();
        w = '0;
        for (int e = 0; e < NE; e++) w[e*4 +: 4] = ef[e];
        checks++;
        if (wrd_data !== w) begin
            errors++;
            $display("FAIL %s wide read actual %h expected %h", tag, wrd_data, w);
        end
        for (int r = 0; r < NR; r++) begin
            o = '0;
            for (int e = 0; e < NE; e++) if (nrd_sel[r][e]) o = o | ef[e];
            checks++;
            if (nrd_data[r] !== o) begin
                errors++;
                $display("FAIL %s read port %0d actual %h expected %h", tag, r, nrd_data[r], o);
            end
        end
    endtask

    task automatic clear_in();
        nrd_sel = '0; nwr_sel = '0; nwr_data = '0; wwr_en = 1'b0; wwr_data = '0;
    endtask

    // inputs set at falling edge; check 1 unit later; model advances at rising edge
    task automatic cycle(input string tag);
        #1;
        check_all(tag);
        @(posedge clk);
        for (int e = 0; e < NE; e++) model[e] = rst ? 4'h0 : ef[e];
        @(negedge clk);
    endtask

    task automatic tick_reset();
        @(posedge clk);
        for (int e = 0; e < NE; e++) model[e] = 4'h0;
        @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD*100000);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        clear_in();
        rst = 1'b1;
        for (int e = 0; e < NE; e++) model[e] = 4'h0;
        @(negedge clk);
        tick_reset();
        tick_reset();
        rst = 1'b0;
        // R1: reset state, every port reads its own entry
        for (int r = 0; r < NR; r++) nrd_sel[r] = 8'(1 << r);
        cycle("R1");

        // R5 / R2: every write port against every entry
        for (int p = 0; p < NW; p++) begin
            for (int e = 0; e < NE; e++) begin
                clear_in();
                nwr_sel[p]  = 8'(1 << e);
                nwr_data[p] = 4'((p + 3*e + 1) % 16);
                nrd_sel[NR-1-p] = 8'(1 << e);
                nrd_sel[p] = nrd_sel[p] | 8'(1 << ((e + 1) % NE));
                cycle("R5");
                clear_in();
                nrd_sel[p] = 8'(1 << e);
                cycle("R2");
            end
        end

        // R3: deselected ports zero, one-hot reads each entry
        clear_in();
        cycle("R3");
        for (int e = 0; e < NE; e++) begin
            for (int r = 0; r < NR; r++) nrd_sel[r] = 8'(1 << e);
            cycle("R3");
        end

        // distinct contents for OR sweep
        clear_in();
        wwr_en = 1'b1; wwr_data = 32'h8421_6CA3;
        cycle("R6");
        // R4: all select patterns on port 0
        clear_in();
        for (int s = 0; s < 256; s++) begin
            nrd_sel[0] = 8'(s);
            nrd_sel[1] = ~8'(s);
            cycle("R4");
        end

        // R6: wide write layout, then stored
        clear_in();
        wwr_en = 1'b1; wwr_data = 32'h9E3A_5C71;
        for (int r = 0; r < NR; r++) nrd_sel[r] = 8'(1 << r);
        cycle("R6");
        wwr_en = 1'b0;
        cycle("R6");

        // R8: narrow beats wide on the same entry
        clear_in();
        wwr_en = 1'b1; wwr_data = 32'hFFFF_FFFF;
        nwr_sel[2] = 8'h08; nwr_data[2] = 4'h5;
        nwr_sel[0] = 8'h80; nwr_data[0] = 4'h2;
        nrd_sel[0] = 8'h08; nrd_sel[1] = 8'h80;
        cycle("R8");
        clear_in();
        nrd_sel[0] = 8'h08; nrd_sel[1] = 8'h80;
        cycle("R8");

        // R9: highest narrow port wins
        clear_in();
        for (int p = 0; p < NW; p++) begin nwr_sel[p] = 8'h20; nwr_data[p] = 4'(p + 8); end
        nrd_sel[3] = 8'h20;
        cycle("R9");
        clear_in();
        nwr_sel[1] = 8'h01; nwr_data[1] = 4'h3;
        nwr_sel[4] = 8'h01; nwr_data[4] = 4'hC;
        nrd_sel[0] = 8'h01; nrd_sel[5] = 8'h20;
        cycle("R9");
        clear_in();
        nrd_sel[0] = 8'h01; nrd_sel[5] = 8'h20;
        cycle("R9");

        // R10: one port, several entries
        clear_in();
        nwr_sel[3] = 8'hA5; nwr_data[3] = 4'h9;
        cycle("R10");
        clear_in();
        for (int r = 0; r < NR; r++) nrd_sel[r] = 8'(1 << r);
        cycle("R10");

        // R7: wide read forwards a mix of narrow and wide writes
        clear_in();
        nwr_sel[6] = 8'h42; nwr_data[6] = 4'h7;
        cycle("R7");
        clear_in();
        wwr_en = 1'b1; wwr_data = 32'h1357_9BDF;
        nwr_sel[5] = 8'h10; nwr_data[5] = 4'h0;
        cycle("R7");

        // R11: idle cycles leave contents intact
        clear_in();
        for (int r = 0; r < NR; r++) nrd_sel[r] = 8'(1 << (NE - 1 - r));
        cycle("R11");
        cycle("R11");

        // R12: reset with concurrent writes
        clear_in();
        rst = 1'b1;
        wwr_en = 1'b1; wwr_data = 32'hDEAD_BEEF;
        nwr_sel[7] = 8'hFF; nwr_data[7] = 4'hA;
        tick_reset();
        rst = 1'b0;
        clear_in();
        for (int r = 0; r < NR; r++) nrd_sel[r] = 8'hFF;
        cycle("R12");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule